// File: doc/BRIEF.md
# Line-alternating phase-corrected clock divider

This block turns a master clock running at six times the colour subcarrier into a one-cycle clock enable at half that rate, which paces a system clock at three times the subcarrier. The subcarrier-to-line frequency ratio is not an integer. To keep the sample grid aligned from line to line, the divide-by-two stage is held for one master-clock cycle at the start of every second line. That hold shifts the system clock by 180 degrees.

The block also issues a one-cycle line-start strobe that addresses the delay lines. A free-running count of system-clock cycles per line produces the strobe. The count is forced back into step with horizontal sync once per field, at the first horizontal edge after a vertical pulse. Both sync inputs arrive asynchronously, so they are synchronised and edge-detected inside the block. A run enable from the mode controller stops all clock processing.

Top module: `phase_flip_divider`

## Requirements
- R1: While `run_en` is high, `sys_ce` inverts on every master-clock cycle except correction cycles.
- R2: A rising edge on `hsync_in` that begins an odd line holds `sys_ce` at its value for exactly one cycle. The hold takes effect on the third rising clock edge after the input edge: two synchroniser stages, then edge detection.
- R3: `line_odd` inverts on every detected rising horizontal edge, on the same clock edge as R2, and otherwise keeps its value.
- R4: A rising edge on `vsync_in` arms a field resync. At the next detected horizontal edge the block clears `line_odd` to 0 with no hold, pulses `line_start` high for one cycle and restarts the line count.
- R5: After a resync, `line_start` pulses once every `LINE_CYC` `sys_ce` pulses. The pulse appears on the clock edge that follows the `LINE_CYC`-th high cycle of `sys_ce` counted since the previous strobe.
- R6: While `run_en` is low, `sys_ce`, `line_start` and `line_odd` are low, and any armed field resync is dropped. After `run_en` returns high, no `line_start` appears until a field resync has taken place.
- R7: After reset, `sys_ce`, `line_odd` and `line_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mck | input | 1 | Master clock, six times the subcarrier |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Clock processing enable from the mode controller |
| hsync_in | input | 1 | Horizontal sync pulse, asynchronous |
| vsync_in | input | 1 | Vertical sync pulse, asynchronous |
| sys_ce | output | 1 | System clock enable at half the master rate |
| line_odd | output | 1 | Line parity, 1 on corrected lines |
| line_start | output | 1 | One-cycle delay-line start strobe |

## Verification
A divider stuck in the wrong phase shows up as a missing or extra repeated `sys_ce` value on the third clock after a horizontal edge. A wrong parity bit shows up on `line_odd` in that same cycle. A miscounted line counter is visible only after a complete line of `LINE_CYC` enables, when the strobe comes early or late. For that reason the bench runs several whole lines between resyncs. A lost field arm shows up as a missing strobe at the first horizontal edge after the vertical pulse. It also leaves the strobes absent after the enable returns.

// File: rtl/phase_flip_divider.sv
`timescale 1ns/1ps
module phase_flip_divider #(
  parameter int LINE_CYC    = 851,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_mck,
  input  logic rst_n,
  input  logic run_en,
  input  logic hsync_in,
  input  logic vsync_in,
  output logic sys_ce,
  output logic line_odd,
  output logic line_start
);

  localparam int CW = (LINE_CYC > 1) ? $clog2(LINE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(LINE_CYC - 1);

  logic [SYNC_STAGES-1:0] hs_sh, vs_sh;
  logic hs_d, vs_d;
  logic div_ph, v_armed, aligned;
  logic [CW-1:0] cnt;
  logic h_rise, v_rise, resync, next_odd, hold, wrap;

  always_ff @(posedge clk_mck or negedge rst_n) begin
    if (!rst_n) begin
      hs_sh <= '0;
      vs_sh <= '0;
      hs_d  <= 1'b0;
      vs_d  <= 1'b0;
    end else begin
      hs_sh <= {hs_sh[SYNC_STAGES-2:0], hsync_in};
      vs_sh <= {vs_sh[SYNC_STAGES-2:0], vsync_in};
      hs_d  <= hs_sh[SYNC_STAGES-1];
      vs_d  <= vs_sh[SYNC_STAGES-1];
    end
  end

  assign h_rise   = run_en & hs_sh[SYNC_STAGES-1] & ~hs_d;
  assign v_rise   = run_en & vs_sh[SYNC_STAGES-1] & ~vs_d;
  assign resync   = h_rise & v_armed;
  assign next_odd = ~resync & ~line_odd;
  assign hold     = h_rise & next_odd;
  assign wrap     = div_ph & (cnt == LAST);
  assign sys_ce   = div_ph;

  always_ff @(posedge clk_mck or negedge rst_n) begin
    if (!rst_n)       div_ph <= 1'b0;
    else if (!run_en) div_ph <= 1'b0;
    else if (!hold)   div_ph <= ~div_ph;
  end

  always_ff @(posedge clk_mck or negedge rst_n) begin
    if (!rst_n)       line_odd <= 1'b0;
    else if (!run_en) line_odd <= 1'b0;
    else if (h_rise)  line_odd <= next_odd;
  end

  always_ff @(posedge clk_mck or negedge rst_n) begin
    if (!rst_n) begin
      v_armed <= 1'b0;
      aligned <= 1'b0;
    end else if (!run_en) begin
      v_armed <= 1'b0;
      aligned <= 1'b0;
    end else begin
      if (v_rise)      v_armed <= 1'b1;
      else if (resync) v_armed <= 1'b0;
      if (resync)      aligned <= 1'b1;
    end
  end

  always_ff @(posedge clk_mck or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run_en) cnt <= '0;
    else if (resync)  cnt <= '0;
    else if (div_ph)  cnt <= wrap ? '0 : cnt + CW'(1);
  end

  always_ff @(posedge clk_mck or negedge rst_n) begin
    if (!rst_n) line_start <= 1'b0;
    else        line_start <= run_en & (resync | (aligned & wrap));
  end

  a_r1_toggle: assert property (@(posedge clk_mck) disable iff (!rst_n)
    (run_en && !hold) |=> (sys_ce != $past(sys_ce)));

  a_r2_hold_once: assert property (@(posedge clk_mck) disable iff (!rst_n)
    hold |=> (sys_ce == $past(sys_ce)) && !hold);

  a_r3_parity_stable: assert property (@(posedge clk_mck) disable iff (!rst_n)
    (run_en && !h_rise) |=> $stable(line_odd));

  a_r4_resync_strobe: assert property (@(posedge clk_mck) disable iff (!rst_n)
    resync |=> line_start && !line_odd);

  a_r6_stopped: assert property (@(posedge clk_mck) disable iff (!rst_n)
    !run_en |=> !sys_ce && !line_start && !line_odd);

endmodule

// File: tb/test_phase_flip_divider.sv
`timescale 1ns/1ps
module test_phase_flip_divider;
  localparam int LC = 24;

  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, hsync = 1'b0, vsync = 1'b0;
  logic sys_ce, line_odd, line_start;

  phase_flip_divider #(.LINE_CYC(LC), .SYNC_STAGES(2)) i_phase_flip_divider (
    .clk_mck(clk), .rst_n(rst_n), .run_en(run_en), .hsync_in(hsync),
    .vsync_in(vsync), .sys_ce(sys_ce), .line_odd(line_odd), .line_start(line_start));

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  int q_rs[$], q_fz[$];
  bit bpar = 0, b_armed = 0, b_al = 0, prev_ce = 0, run_prev = 0, run_now = 0, done = 0;
  int ce_count = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
  endtask

  // driver: pushes expected freeze and resync cycles
  task automatic pulse_h(int gap);
    int n;
    bit np;
    @(negedge clk);
    hsync = 1'b1;
    n = cyc;
    if (!run_en) np = 1'b0;
    else if (b_armed) begin
      np = 1'b0;
      b_armed = 1'b0;
      q_rs.push_back(n + 3);
    end else begin
      np = ~bpar;
      if (np) q_fz.push_back(n + 3);
    end
    bpar = np;
    repeat (3) @(negedge clk);
    chk(line_odd == np, "R3", "line_odd after h edge", line_odd, np);
    @(negedge clk);
    hsync = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulse_v(int gap);
    @(negedge clk);
    vsync = 1'b1;
    if (run_en) b_armed = 1'b1;
    repeat (4) @(negedge clk);
    vsync = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // monitor: pops and compares as the design produces events
  always @(posedge clk) begin
    run_now = run_en;
    #1;
    cyc++;
    if (rst_n && !done) begin
      if (q_fz.size() > 0 && q_fz[0] < cyc) begin
        chk(0, "R2", "hold missing at cycle", cyc, q_fz[0]);
        void'(q_fz.pop_front());
      end
      if (q_rs.size() > 0 && q_rs[0] < cyc) begin
        chk(0, "R4", "resync strobe missing at cycle", cyc, q_rs[0]);
        void'(q_rs.pop_front());
      end
      if (run_now && run_prev) begin
        if (sys_ce == prev_ce) begin
          if (q_fz.size() > 0 && q_fz[0] == cyc) begin
            chk(1, "R2", "hold", 1, 1);
            void'(q_fz.pop_front());
          end else chk(0, "R1", "unexpected repeat of sys_ce at cycle", cyc, -1);
        end else if (q_fz.size() > 0 && q_fz[0] == cyc) begin
          chk(0, "R2", "no hold at cycle", cyc, q_fz[0]);
          void'(q_fz.pop_front());
        end
      end
      if (!run_now) begin
        chk(!sys_ce && !line_start && !line_odd, "R6", "outputs while stopped",
            {sys_ce, line_start, line_odd}, 0);
        b_al = 1'b0;
        ce_count = 0;
      end else if (q_rs.size() > 0 && q_rs[0] == cyc) begin
        chk(line_start, "R4", "resync strobe", line_start, 1);
        void'(q_rs.pop_front());
        b_al = 1'b1;
        ce_count = 0;
      end else begin
        bit exp_s;
        exp_s = b_al && prev_ce && (ce_count == LC - 1);
        if (exp_s || line_start)
          chk(line_start == exp_s, b_al ? "R5" : "R6", "line_start", line_start, exp_s);
        if (line_start) ce_count = 0;
        else if (prev_ce) ce_count++;
      end
    end
    prev_ce  = sys_ce;
    run_prev = run_now;
  end

  initial begin
    #(5.0 * 150000);
    chk(0, "WD", "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!sys_ce && !line_odd && !line_start, "R7", "reset state",
        {sys_ce, line_odd, line_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_en = 1'b1;
    repeat (10) @(negedge clk);
    pulse_h(40);                        // R2 R3 before any field resync: no strobe
    pulse_h(40);
    pulse_v(20);
    pulse_h(50);                        // R4
    for (int i = 0; i < 6; i++) pulse_h(45 + i * 3);  // R5 free-running lines
    pulse_v(10);
    pulse_h(60);
    pulse_h(60);
    @(negedge clk);
    run_en = 1'b0;                      // R6
    bpar = 1'b0;
    b_armed = 1'b0;
    repeat (5) @(negedge clk);
    pulse_v(10);
    pulse_h(30);
    pulse_h(30);
    run_en = 1'b1;
    repeat (5) @(negedge clk);
    pulse_h(60);                        // R6 no strobe until resync
    pulse_h(60);
    pulse_h(60);
    pulse_v(10);
    pulse_h(70);
    for (int i = 0; i < 3; i++) pulse_h(50);
    repeat (10) @(negedge clk);
    done = 1'b1;
    chk(q_fz.size() == 0, "R2", "holds left unseen", q_fz.size(), 0);
    chk(q_rs.size() == 0, "R4", "resyncs left unseen", q_rs.size(), 0);
    summary();
    $finish;
  end
endmodule